// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block keeps the status register of a 2 Mbit serial flash (256 KByte, 18-bit byte address). It does not handle the memory array or the serial shifter. A command decoder upstream gives it one-cycle strobes for write-enable, write-disable, status-write enable and status write. It also gives it program and erase requests, each with a target address. The block answers every request with a registered grant or deny pulse, and it drives the status byte that a status read shifts out.

Two things decide whether a request is allowed. A two-bit range field protects none, the top quarter, the top half or the whole array. Two sticky sector-lock flags guard the highest and the lowest 4 KByte sector. A lock bit combined with the active-low write-protect pin can freeze the range field. A granted operation clears the write-enable latch and holds the busy flag for a fixed number of cycles. During that time every command is ignored. An auto-increment program grant sets the AAI bit and leaves the write-enable latch set.

Top module: `fsr_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x0C (bits 3:2 range = 11, every other bit 0) and both lock flags are 0.
- R2: A write-enable strobe sets WEL (status bit 1). A write-disable strobe clears WEL and AAI (status bit 6).
- R3: An accepted status write copies only wr_data bits 3:2 into the range field and bit 7 into the lock bit. Status bits 1, 0 and 6 come only from the block's own state, never from wr_data. An accepted status write clears WEL.
- R4: A status write is ignored while the lock bit is 1 and wp_n is 0. With wp_n at 1 the same write is accepted.
- R5: A status write is accepted only when WEL is 1, or when the previous command strobe was status-write enable. In any other case it is ignored.
- R6: Range 00 protects nothing, 01 protects 0x30000 to 0x3FFFF, 10 protects 0x20000 to 0x3FFFF, and 11 protects the whole array.
- R7: When the top lock flag is set, addresses 0x3F000 to 0x3FFFF are refused. When the bottom lock flag is set, addresses 0x00000 to 0x00FFF are refused. Each flag stays set until reset.
- R8: A request made while WEL is 0 is denied.
- R9: A granted request gives op_grant for one cycle after the request edge, clears WEL and holds BUSY (status bit 0) for OP_CYCLES cycles.
- R10: A denied request gives op_deny for one cycle, leaves WEL unchanged and does not raise BUSY.
- R11: A chip erase is granted only when the range field is 00 and neither lock flag is set.
- R12: While BUSY is 1, all strobes and requests are ignored.
- R13: A granted auto-increment program sets AAI and keeps WEL set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_ewsr | input | 1 | Status-write enable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wr_data | input | 8 | New status value for a status write |
| op_req | input | 1 | Program or erase request strobe |
| op_chip | input | 1 | The request is a whole-chip erase |
| op_aai | input | 1 | The request is an auto-increment program |
| op_addr | input | 18 | Target byte address |
| lock_top_set | input | 1 | Sets the top-sector lock flag |
| lock_bot_set | input | 1 | Sets the bottom-sector lock flag |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 8 | Status byte {lock, AAI, 00, range, WEL, BUSY} |
| lock_flags | output | 2 | {top lock, bottom lock} |
| op_grant | output | 1 | Request accepted (one-cycle pulse) |
| op_deny | output | 1 | Request refused (one-cycle pulse) |

## Verification
The hardest case to reach is a status write that arrives after a status-write enable, but with a different command strobe in between. The arming must be gone by then, so the write has to be ignored. The stimulus clears WEL, arms with status-write enable and then sends a write-disable. Only after that does it issue the status write, and it checks that the range field has not moved. Each entry in the protection table needs its own reset, because the lock flags can only be cleared by reset. It also needs the range field programmed through the normal status-write path before the request, and that path only works while the lock bit is clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int ADDR_W = 18;
    localparam int SECT_W = 12;

    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
        logic       bpl;
        logic       aai;
        logic       tsp;
        logic       bsp;
        logic       armed;
        logic       grant;
        logic       deny;
    } ctl_t;

endpackage

// File: rtl/fsr_protect_check.sv
module fsr_protect_check #(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip,
    input  logic [1:0]        bp,
    input  logic              tsp,
    input  logic              bsp,
    output logic              prot
);
    localparam int HI_W = ADDR_W - SECT_W;

    logic [HI_W-1:0] sect_idx;
    logic            in_range;
    logic            top_sect;
    logic            bot_sect;

    always_comb begin
        sect_idx = addr[ADDR_W-1:SECT_W];
        top_sect = &sect_idx;
        bot_sect = ~|sect_idx;
        case (bp)
            2'b00:   in_range = 1'b0;
            2'b01:   in_range = &addr[ADDR_W-1:ADDR_W-2];
            2'b10:   in_range = addr[ADDR_W-1];
            default: in_range = 1'b1;
        endcase
        if (chip) prot = (bp != 2'b00) || tsp || bsp;
        else      prot = in_range || (tsp && top_sect) || (bsp && bot_sect);
    end
endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLES - 1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;

    // R9: busy holds while the count is not yet exhausted
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != '0) |=> tmr_q.busy);
endmodule

// File: rtl/fsr_status_ctrl.sv
module fsr_status_ctrl
    import fsr_pkg::*;
#(
    parameter int OP_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_ewsr,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wr_data,
    input  logic              op_req,
    input  logic              op_chip,
    input  logic              op_aai,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              lock_top_set,
    input  logic              lock_bot_set,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic [1:0]        lock_flags,
    output logic              op_grant,
    output logic              op_deny
);
    ctl_t ctl_d, ctl_q;
    logic busy;
    logic prot;
    logic other_cmd;
    logic sr_locked;

    fsr_protect_check #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_prot (
        .addr (op_addr),
        .chip (op_chip),
        .bp   (ctl_q.bp),
        .tsp  (ctl_q.tsp),
        .bsp  (ctl_q.bsp),
        .prot (prot)
    );

    fsr_busy_timer #(.CYCLES(OP_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctl_d.grant),
        .busy  (busy)
    );

    always_comb begin
        other_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | op_req | lock_top_set | lock_bot_set;
        sr_locked = ctl_q.bpl && !wp_n;
        ctl_d       = ctl_q;
        ctl_d.grant = 1'b0;
        ctl_d.deny  = 1'b0;
        if (!busy) begin
            if (cmd_ewsr)       ctl_d.armed = 1'b1;
            else if (other_cmd) ctl_d.armed = 1'b0;

            if (cmd_wrdi) begin
                ctl_d.wel = 1'b0;
                ctl_d.aai = 1'b0;
            end else if (cmd_wren) begin
                ctl_d.wel = 1'b1;
            end else if (cmd_wrsr) begin
                if ((ctl_q.armed || ctl_q.wel) && !sr_locked) begin
                    ctl_d.bp  = wr_data[3:2];
                    ctl_d.bpl = wr_data[7];
                    ctl_d.wel = 1'b0;
                end
            end else if (op_req) begin
                if (ctl_q.wel && !prot) begin
                    ctl_d.grant = 1'b1;
                    if (op_aai && !op_chip) ctl_d.aai = 1'b1;
                    else                    ctl_d.wel = 1'b0;
                end else begin
                    ctl_d.deny = 1'b1;
                end
            end

            if (lock_top_set) ctl_d.tsp = 1'b1;
            if (lock_bot_set) ctl_d.bsp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.bp <= 2'b11;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status     = {ctl_q.bpl, ctl_q.aai, 2'b00, ctl_q.bp, ctl_q.wel, busy};
    assign lock_flags = {ctl_q.tsp, ctl_q.bsp};
    assign op_grant   = ctl_q.grant;
    assign op_deny    = ctl_q.deny;

    // R12: nothing changes while busy
    assert_busy_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ctl_q.bp) && $stable(ctl_q.bpl) && $stable(ctl_q.wel)));

    // R4: a locked status register ignores writes
    assert_locked_sr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !wp_n && ctl_q.bpl) |=> ($stable(ctl_q.bp) && $stable(ctl_q.bpl)));

    // R10: a refusal never starts the busy period
    assert_deny_no_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_deny |-> !busy);

    // R9: a plain grant leaves the write-enable latch cleared while busy
    assert_grant_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_grant && !ctl_q.aai) |-> (busy && !ctl_q.wel));

    // R8: a grant only follows a cycle with the latch set
    assert_grant_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_grant) |-> $past(ctl_q.wel));
endmodule

// File: tb/test_fsr_status_ctrl.sv
module test_fsr_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OPC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_ewsr = 0, cmd_wrsr = 0;
    logic [7:0] wr_data = '0;
    logic op_req = 0, op_chip = 0, op_aai = 0;
    logic [17:0] op_addr = '0;
    logic lock_top_set = 0, lock_bot_set = 0, wp_n = 1;
    logic [7:0] status;
    logic [1:0] lock_flags;
    logic op_grant, op_deny;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsr_status_ctrl #(.OP_CYCLES(OPC)) i_fsr_status_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_ewsr(cmd_ewsr), .cmd_wrsr(cmd_wrsr), .wr_data(wr_data),
        .op_req(op_req), .op_chip(op_chip), .op_aai(op_aai), .op_addr(op_addr),
        .lock_top_set(lock_top_set), .lock_bot_set(lock_bot_set), .wp_n(wp_n),
        .status(status), .lock_flags(lock_flags), .op_grant(op_grant), .op_deny(op_deny)
    );

    // {bp[1:0], tsp, bsp, chip, addr[17:0], expect_grant}
    localparam logic [23:0] VEC [13] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0, 18'h30000, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 18'h2FFFF, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b0, 18'h20000, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 18'h1FFFF, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0, 18'h3F000, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0, 18'h3EFFF, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b0, 18'h00FFF, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0, 18'h01000, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b1, 18'h00000, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b1, 18'h00000, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b1, 18'h00000, 1'b0}
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_ewsr = 0; cmd_wrsr = 0;
        op_req = 0; op_chip = 0; op_aai = 0;
        lock_top_set = 0; lock_bot_set = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic wren();  cmd_wren = 1; tick(); endtask
    task automatic wrdi();  cmd_wrdi = 1; tick(); endtask
    task automatic ewsr();  cmd_ewsr = 1; tick(); endtask
    task automatic wrsr(input logic [7:0] v); wr_data = v; cmd_wrsr = 1; tick(); endtask
    task automatic req(input logic [17:0] a, input logic chip, input logic aai);
        op_addr = a; op_chip = chip; op_aai = aai; op_req = 1; tick();
    endtask
    task automatic wait_idle();
        while (status[0]) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // table walk: R6, R7, R11
        foreach (VEC[i]) begin
            automatic logic [23:0] v = VEC[i];
            do_reset();
            if (v[21]) begin lock_top_set = 1; tick(); end
            if (v[20]) begin lock_bot_set = 1; tick(); end
            wren();
            wrsr({4'b0000, v[23:22], 2'b00});
            wren();
            req(v[18:1], v[19], 1'b0);
            check({31'd0, op_grant}, {31'd0, v[0]}, $sformatf("R6_R7_R11 vec%0d grant", i));
            check({31'd0, op_deny}, {31'd0, ~v[0]}, $sformatf("R6_R7_R11 vec%0d deny", i));
            wait_idle();
        end

        // R1 reset value
        do_reset();
        check(status, 8'h0C, "R1 status");
        check(lock_flags, 2'b00, "R1 locks");

        // R2
        wren();
        check(status, 8'h0E, "R2 wren");
        wrdi();
        check(status, 8'h0C, "R2 wrdi");

        // R3 field mask and WEL clear
        ewsr();
        wrsr(8'hFF);
        check(status, 8'h8C, "R3 write FF");
        wren();
        wrsr(8'h73);
        check(status, 8'h00, "R3 write 73 via WEL");

        // R5 arming lost behind another command
        ewsr();
        wrdi();
        wrsr(8'h0C);
        check(status, 8'h00, "R5 stale arm");
        wrsr(8'h0C);
        check(status, 8'h00, "R5 no enable");

        // R4 lock with pin
        ewsr();
        wrsr(8'h8C);
        check(status, 8'h8C, "R4 set lock");
        wp_n = 0;
        ewsr();
        wrsr(8'h00);
        check(status, 8'h8C, "R4 locked");
        wp_n = 1;
        ewsr();
        wrsr(8'h00);
        check(status, 8'h00, "R4 unlocked");

        // R8 no WEL
        req(18'h00100, 1'b0, 1'b0);
        check({op_grant, op_deny}, 2'b01, "R8 deny");
        check(status, 8'h00, "R8 status");

        // R10 denied keeps WEL
        ewsr();
        wrsr(8'h0C);
        wren();
        req(18'h00100, 1'b0, 1'b0);
        check({op_grant, op_deny}, 2'b01, "R10 deny");
        check(status, 8'h0E, "R10 wel kept");
        tick();
        check(status, 8'h0E, "R10 no busy");

        // R9 busy length, R12 ignored while busy
        wrsr(8'h00);
        wren();
        req(18'h10000, 1'b0, 1'b0);
        check({op_grant, op_deny}, 2'b10, "R9 grant");
        check(status, 8'h01, "R9 busy no wel");
        begin
            int n = 0;
            cmd_wren = 1;
            while (status[0] && n < 50) begin n++; tick(); end
            check(n, OPC, "R9 busy cycles");
        end
        check(status, 8'h00, "R12 wren ignored while busy");
        tick();
        check({op_grant, op_deny}, 2'b00, "R9 single pulse");

        // R13 AAI
        wren();
        req(18'h00200, 1'b0, 1'b1);
        check(status, 8'h43, "R13 aai busy");
        wait_idle();
        check(status, 8'h42, "R13 aai idle");
        wrdi();
        check(status, 8'h00, "R2 wrdi clears aai");

        // R7 flags sticky
        lock_top_set = 1; tick();
        check(lock_flags, 2'b10, "R7 top flag");
        lock_bot_set = 1; tick();
        check(lock_flags, 2'b11, "R7 both flags");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule